// File: doc/BRIEF.md
# Boolean Bit Processor

This block carries out single-bit operations using a one-bit accumulator, the carry. Each cycle in which `op_valid` is high, it decodes a 3-bit operation code and takes one bit value, `bit_rd`. The caller reads that bit from an external bit-addressable store. The block can do three things with it:

- fold the bit, or its inverse, into the carry with AND or OR;
- force, clear or toggle either the carry or the bit;
- perform an atomic test-and-clear that reports a branch.

Address decoding and storage stay outside the block. The block only asks for a write of the bit through `bit_wr_en` and `bit_wr_data`, and the caller applies that write to the same location it read from.

The write request and the branch flag are combinational. They are valid in the same cycle as the strobe. The carry is a register and takes its new value at the clock edge that ends the strobed cycle. When `op_valid` is low, nothing changes.

Top module: `bool_bit_unit`

## Requirements
- R1: Codes 3'b000 and 3'b001 load the carry, at the closing edge of the strobed cycle, with `carry & bit_rd` and `carry & ~bit_rd` respectively.
- R2: Codes 3'b010 and 3'b011 load the carry with `carry | bit_rd` and `carry | ~bit_rd` respectively.
- R3: With `op_on_carry` = 0, codes 3'b100, 3'b101 and 3'b110 raise `bit_wr_en` in the same cycle, with `bit_wr_data` equal to 1, 0 or `~bit_rd` respectively. The carry is unchanged.
- R4: With `op_on_carry` = 1, codes 3'b100, 3'b101 and 3'b110 load the carry with 1, 0 or its own inverse respectively. No bit write is requested.
- R5: Codes 3'b000 to 3'b011 never request a bit write, so the source bit is left as it was, even when its inverse is used.
- R6: Code 3'b111 with `bit_rd` = 1 raises `branch_taken` and `bit_wr_en` in the same cycle, with `bit_wr_data` = 0. The carry is unchanged.
- R7: Code 3'b111 with `bit_rd` = 0 gives `branch_taken` = 0 and requests no write.
- R8: With `op_valid` low, no write or branch is signalled and the carry holds, whatever the code and bit inputs are.
- R9: While `rst_n` is low, the carry is forced to the parameter `CARRY_INIT` (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Single-cycle operation strobe |
| op_code | input | 3 | Operation code |
| op_on_carry | input | 1 | Set/clear/toggle target: 1 = carry, 0 = bit |
| bit_rd | input | 1 | Value of the addressed bit |
| carry | output | 1 | Boolean accumulator |
| bit_wr_en | output | 1 | Write request for the addressed bit |
| bit_wr_data | output | 1 | Value to write to the addressed bit |
| branch_taken | output | 1 | Test-and-clear found the bit set |

## Verification
A decode fault shows up in the same cycle on `bit_wr_en`, `bit_wr_data` or `branch_taken`. A faulty carry update appears on `carry` one edge later.

Because the carry feeds later AND and OR steps, a wrong carry also spreads into the operations that follow. The vector sequence therefore chains its operations, so that each carry value is both observed on the port and reused by the next step.

// File: rtl/bbp_pkg.sv
package bbp_pkg;

   typedef enum logic [2:0] {
      OP_AND  = 3'b000,
      OP_ANDN = 3'b001,
      OP_OR   = 3'b010,
      OP_ORN  = 3'b011,
      OP_SET  = 3'b100,
      OP_CLR  = 3'b101,
      OP_CPL  = 3'b110,
      OP_TCLR = 3'b111
   } bop_e;

   typedef enum logic [1:0] {
      UN_NONE = 2'd0,
      UN_SET  = 2'd1,
      UN_CLR  = 2'd2,
      UN_CPL  = 2'd3
   } unary_e;

   typedef struct packed {
      logic   combine;
      logic   use_or;
      logic   invert;
      unary_e unary;
      logic   on_carry;
      logic   test_clear;
   } bctl_t;

endpackage

// File: rtl/bbp_decode.sv
module bbp_decode
   import bbp_pkg::*;
#(
   parameter int TCLR_EN = 1
) (
   input  logic       valid,
   input  logic [2:0] code,
   input  logic       on_carry,
   output bctl_t      ctl
);

   logic tclr_ok;

   generate
      if (TCLR_EN != 0) begin : g_tclr
         assign tclr_ok = 1'b1;
      end else begin : g_no_tclr
         assign tclr_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      ctl = '0;
      if (valid) begin
         case (bop_e'(code))
            OP_AND:  ctl.combine = 1'b1;
            OP_ANDN: begin ctl.combine = 1'b1; ctl.invert = 1'b1; end
            OP_OR:   begin ctl.combine = 1'b1; ctl.use_or = 1'b1; end
            OP_ORN:  begin
               ctl.combine = 1'b1;
               ctl.use_or  = 1'b1;
               ctl.invert  = 1'b1;
            end
            OP_SET:  begin ctl.unary = UN_SET; ctl.on_carry = on_carry; end
            OP_CLR:  begin ctl.unary = UN_CLR; ctl.on_carry = on_carry; end
            OP_CPL:  begin ctl.unary = UN_CPL; ctl.on_carry = on_carry; end
            OP_TCLR: ctl.test_clear = tclr_ok;
            default: ctl = '0;
         endcase
      end
   end

endmodule

// File: rtl/bbp_alu.sv
module bbp_alu
   import bbp_pkg::*;
(
   input  bctl_t ctl,
   input  logic  carry_q,
   input  logic  bit_rd,
   output logic  carry_nxt,
   output logic  wr_en,
   output logic  wr_data,
   output logic  branch
);

   logic src;
   logic target;
   logic un_val;

   assign src    = bit_rd ^ ctl.invert;
   assign target = ctl.on_carry ? carry_q : bit_rd;

   always_comb begin
      case (ctl.unary)
         UN_SET:  un_val = 1'b1;
         UN_CLR:  un_val = 1'b0;
         UN_CPL:  un_val = ~target;
         default: un_val = target;
      endcase
   end

   always_comb begin
      carry_nxt = carry_q;
      wr_en     = 1'b0;
      wr_data   = 1'b0;
      branch    = 1'b0;
      if (ctl.combine) begin
         carry_nxt = ctl.use_or ? (carry_q | src) : (carry_q & src);
      end
      if (ctl.unary != UN_NONE) begin
         if (ctl.on_carry) begin
            carry_nxt = un_val;
         end else begin
            wr_en   = 1'b1;
            wr_data = un_val;
         end
      end
      if (ctl.test_clear && bit_rd) begin
         branch  = 1'b1;
         wr_en   = 1'b1;
         wr_data = 1'b0;
      end
   end

endmodule

// File: rtl/bool_bit_unit.sv
module bool_bit_unit
   import bbp_pkg::*;
#(
   parameter bit CARRY_INIT = 1'b0,
   parameter int TCLR_EN    = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       op_valid,
   input  logic [2:0] op_code,
   input  logic       op_on_carry,
   input  logic       bit_rd,
   output logic       carry,
   output logic       bit_wr_en,
   output logic       bit_wr_data,
   output logic       branch_taken
);

   generate
      if (TCLR_EN != 0 && TCLR_EN != 1) begin : g_bad_param
         initial $fatal(1, "TCLR_EN must be 0 or 1");
      end
   endgenerate

   bctl_t ctl;
   logic  carry_q;
   logic  carry_nxt;

   bbp_decode #(.TCLR_EN(TCLR_EN)) u_decode (
      .valid    (op_valid),
      .code     (op_code),
      .on_carry (op_on_carry),
      .ctl      (ctl)
   );

   bbp_alu u_alu (
      .ctl       (ctl),
      .carry_q   (carry_q),
      .bit_rd    (bit_rd),
      .carry_nxt (carry_nxt),
      .wr_en     (bit_wr_en),
      .wr_data   (bit_wr_data),
      .branch    (branch_taken)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) carry_q <= CARRY_INIT;
      else        carry_q <= carry_nxt;
   end

   assign carry = carry_q;

endmodule

// File: rtl/bool_bit_unit_chk.sv
module bool_bit_unit_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       op_valid,
   input logic [2:0] op_code,
   input logic       op_on_carry,
   input logic       bit_rd,
   input logic       carry,
   input logic       bit_wr_en,
   input logic       bit_wr_data,
   input logic       branch_taken
);

   AST_AND_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code[2:1] == 2'b00) |=> carry == $past(carry & (bit_rd ^ op_code[0]))); // R1
   AST_OR_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code[2:1] == 2'b01) |=> carry == $past(carry | (bit_rd ^ op_code[0]))); // R2
   AST_BIT_UNARY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_on_carry && op_code == 3'b101) |-> (bit_wr_en && !bit_wr_data)); // R3
   AST_BIT_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_on_carry && op_code[2] && op_code != 3'b111) |=> $stable(carry)); // R3
   AST_CARRY_UNARY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_on_carry && op_code == 3'b110) |=> carry != $past(carry)); // R4
   AST_FOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_code[2]) |-> !bit_wr_en); // R5
   AST_TCLR_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 3'b111 && bit_rd) |-> (branch_taken && bit_wr_en && !bit_wr_data)); // R6
   AST_TCLR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 3'b111 && !bit_rd) |-> (!branch_taken && !bit_wr_en)); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |-> (!bit_wr_en && !branch_taken)); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(carry)); // R8

endmodule

bind bool_bit_unit bool_bit_unit_chk u_chk (.*);

// File: tb/bool_bit_unit_test.sv
module bool_bit_unit_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [2:0] op_code = 3'b000;
   logic       op_on_carry = 1'b0;
   logic       bit_rd = 1'b0;
   logic       carry;
   logic       bit_wr_en;
   logic       bit_wr_data;
   logic       branch_taken;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   bool_bit_unit uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_on_carry(op_on_carry), .bit_rd(bit_rd), .carry(carry),
      .bit_wr_en(bit_wr_en), .bit_wr_data(bit_wr_data), .branch_taken(branch_taken)
   );

   typedef struct packed {
      logic [3:0] req;
      logic [2:0] code;
      logic       tgt;
      logic       b;
      logic       we;
      logic       wd;
      logic       br;
      logic       c;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VT [NV] = '{
      '{4'd4, 3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R4 set carry
      '{4'd1, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R1
      '{4'd1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1
      '{4'd1, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1
      '{4'd2, 3'b010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R2
      '{4'd1, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R1 R5
      '{4'd1, 3'b001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 R5
      '{4'd2, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 R5
      '{4'd4, 3'b110, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 toggle carry
      '{4'd2, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
      '{4'd2, 3'b011, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 R5
      '{4'd4, 3'b110, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R4
      '{4'd4, 3'b101, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 clear carry
      '{4'd3, 3'b100, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 set bit
      '{4'd3, 3'b101, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 clear bit
      '{4'd3, 3'b110, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 toggle bit
      '{4'd3, 3'b110, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R3
      '{4'd6, 3'b111, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R6
      '{4'd7, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7
      '{4'd4, 3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R4
      '{4'd6, 3'b111, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}, // R6 carry kept
      '{4'd3, 3'b110, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}  // R3 carry kept
   };

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] c, input logic t, input logic b, input logic v);
      @(negedge clk);
      op_valid    = v;
      op_code     = c;
      op_on_carry = t;
      bit_rd      = b;
      #1;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R9 reset carry", carry, 1'b0);
      check("R9 reset write", bit_wr_en, 1'b0);
      check("R9 reset branch", branch_taken, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         issue(VT[i].code, VT[i].tgt, VT[i].b, 1'b1);
         check($sformatf("R%0d vec%0d wr_en", VT[i].req, i), bit_wr_en, VT[i].we);
         if (VT[i].we) check($sformatf("R%0d vec%0d wr_data", VT[i].req, i), bit_wr_data, VT[i].wd);
         check($sformatf("R%0d vec%0d branch", VT[i].req, i), branch_taken, VT[i].br);
         @(posedge clk);
         #1;
         check($sformatf("R%0d vec%0d carry", VT[i].req, i), carry, VT[i].c);
      end

      // R8: idle cycles with carry = 1 and every code presented
      for (int k = 0; k < 8; k++) begin
         issue(3'(k), k[0], 1'b1, 1'b0);
         check("R8 idle wr_en", bit_wr_en, 1'b0);
         check("R8 idle branch", branch_taken, 1'b0);
         @(posedge clk);
         #1;
         check("R8 idle carry", carry, 1'b1);
      end

      // R5: an OR-with-inverse leaves no write request; the bit remains readable as it was
      issue(3'b011, 1'b0, 1'b1, 1'b1);
      check("R5 orn no write", bit_wr_en, 1'b0);

      // R9: reset in the middle of a run forces carry back to zero
      issue(3'b000, 1'b0, 1'b0, 1'b0);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      check("R9 midrun reset carry", carry, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // R7: a miss right after reset leaves carry at zero
      issue(3'b111, 1'b0, 1'b0, 1'b1);
      check("R7 miss branch", branch_taken, 1'b0);
      check("R7 miss wr_en", bit_wr_en, 1'b0);
      @(posedge clk);
      #1;
      check("R7 miss carry", carry, 1'b0);

      issue(3'b000, 1'b0, 1'b0, 1'b0);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule